// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive path of a DMA-capable network adapter. Software keeps a circular ring of 16-byte descriptors in memory. Each descriptor holds two buffer pointers, one for the packet header and one for the payload. Software announces fresh descriptors by writing a new producer index.

For every packet offered on the input handshake, the engine works in a fixed order:
- it reads the descriptor at the consumer index;
- it writes the header as one cache line;
- it writes the payload as consecutive 64-byte lines;
- it writes a status record back into the descriptor slot;
- it advances the consumer index.

Every outbound write carries a cache-placement enable bit and a target-processor number, both taken from the packet when it was accepted. Completed packets are coalesced into a level interrupt. The interrupt rises when a packet-count threshold or a cycle-timer threshold is reached, whichever comes first. It falls on an acknowledge, which also clears both counters.

The packet parser, the line interface and the memory are not part of the block. They are represented by simple valid/ready and response handshakes.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, `rd_valid`, `wr_valid` and `irq` are low, `cons_idx` is 0, `drop_cnt` is 0 and `pkt_ready` is high.
- R2: When a packet is accepted and a descriptor is available, exactly one descriptor read is issued, at address `ring_base + 16*cons_idx`, before any write for that packet.
- R3: When a packet is accepted while `cons_idx` equals the producer index, it is dropped. `drop_cnt` increments by one, no read or write is issued and `cons_idx` is unchanged.
- R4: Each packet produces its writes in this order, with `wr_kind` encoding 0 = header, 1 = payload, 2 = status:
  - one header write (kind 0) to descriptor bits [31:0];
  - ceil(len/64) payload writes (kind 1) at consecutive 64-byte addresses starting at descriptor bits [63:32];
  - one status write (kind 2) to the descriptor address, with `wr_len` equal to the packet length.
- R5: A zero-length packet produces only the header write and the status write.
- R6: Every write of a packet carries the `pkt_dca` and `pkt_cpu` values sampled when that packet was accepted. Changes to those inputs afterwards have no effect.
- R7: While `wr_valid` is high and `wr_ready` is low, the write outputs hold steady. While `rd_valid` is high and `rd_ready` is low, the read outputs hold steady.
- R8: `cons_idx` advances by exactly one on each accepted status write and wraps modulo the ring size.
- R9: `irq` rises in the cycle in which the PKT_THR-th completed packet since the last acknowledge has its status write accepted.
- R10: With fewer than PKT_THR packets completed, `irq` rises TMR_THR cycles after the first unreported status write is accepted.
- R11: `irq` stays high until `irq_ack`. `irq_ack` drops `irq` on the next edge and clears the packet and timer counts.
- R12: A pulse on `tail_wr` loads `tail_val` as the producer index, making the descriptors from the consumer index up to it available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ring_base | input | ADDR_W | Byte address of ring slot 0 |
| tail_wr | input | 1 | Producer index update strobe |
| tail_val | input | IDX_W | New producer index |
| pkt_valid | input | 1 | Packet offered |
| pkt_len | input | LEN_W | Payload length in bytes (0 to 1460) |
| pkt_dca | input | 1 | Cache-placement enable for this packet |
| pkt_cpu | input | CPU_W | Target processor for this packet |
| pkt_ready | output | 1 | Engine idle; offered packet is taken |
| rd_valid | output | 1 | Descriptor read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Descriptor address |
| rd_rsp_valid | input | 1 | Descriptor data valid |
| rd_rsp_data | input | 2*ADDR_W | Payload pointer (high half) and header pointer (low half) |
| wr_valid | output | 1 | Line write request |
| wr_ready | input | 1 | Line write accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_kind | output | 2 | 0 header, 1 payload, 2 status |
| wr_len | output | LEN_W | Packet length on status writes, else 0 |
| wr_dca | output | 1 | Cache-placement tag |
| wr_cpu | output | CPU_W | Target-processor tag |
| irq | output | 1 | Coalesced interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |
| cons_idx | output | IDX_W | Consumer index |
| drop_cnt | output | DROP_W | Dropped packet count |

## Verification
The write sequence is driven with four payload lengths:
- zero length, which shows the header and status path without any payload lines;
- one line;
- several lines, which show the address step;
- the 1460-byte maximum under write back-pressure, which shows the hold behaviour over a 23-line burst.

The tag inputs are flipped right after acceptance, to tell latched tags from live ones. Interrupt moderation is tried twice:
- a burst of quick packets, which separates the count path;
- a lone packet, which isolates the timer path and its exact latency.

The ring is driven through an empty start, a producer update, a wrap past the last slot and a refill to empty, so that drops are seen both before and after wrap-around.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int LINE_BYTES = 64;
    localparam int DESC_BYTES = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRD   = 3'd1,
        ST_DWAIT = 3'd2,
        ST_HDR   = 3'd3,
        ST_PAY   = 3'd4,
        ST_STS   = 3'd5
    } seq_st_e;

    typedef enum logic [1:0] {
        WK_HDR = 2'd0,
        WK_PAY = 2'd1,
        WK_STS = 2'd2
    } wr_kind_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tail_wr,
    input  logic [IDX_W-1:0] tail_val,
    input  logic             cons_inc,
    output logic [IDX_W-1:0] prod_idx,
    output logic [IDX_W-1:0] cons_idx,
    output logic             ring_empty
);
    typedef struct packed {
        logic [IDX_W-1:0] prod;
        logic [IDX_W-1:0] cons;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (tail_wr) p_d.prod = tail_val;
        if (cons_inc) p_d.cons = p_q.cons + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign prod_idx   = p_q.prod;
    assign cons_idx   = p_q.cons;
    assign ring_empty = (p_q.prod == p_q.cons);
endmodule

// File: rtl/rxr_irq_mod.sv
module rxr_irq_mod #(
    parameter int PKT_THR = 4,
    parameter int TMR_THR = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_done,
    input  logic irq_ack,
    output logic irq
);
    localparam int CNT_W = $clog2(PKT_THR + 1);
    localparam int TMR_W = $clog2(TMR_THR + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [TMR_W-1:0] tmr;
        logic             irq;
    } mod_t;

    mod_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (irq_ack) begin
            m_d = '0;
        end else begin
            if (pkt_done && m_q.cnt != CNT_W'(PKT_THR))
                m_d.cnt = m_q.cnt + CNT_W'(1);
            if (m_q.cnt != '0 && !m_q.irq && m_q.tmr != TMR_W'(TMR_THR))
                m_d.tmr = m_q.tmr + TMR_W'(1);
            m_d.irq = m_q.irq || (m_d.cnt == CNT_W'(PKT_THR))
                              || (m_d.tmr == TMR_W'(TMR_THR));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign irq = m_q.irq;
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
    import rxr_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 32,
    parameter int CPU_W  = 3,
    parameter int LEN_W  = 11,
    parameter int DROP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic [IDX_W-1:0]    cons_idx,
    input  logic                ring_empty,
    input  logic                pkt_valid,
    input  logic [LEN_W-1:0]    pkt_len,
    input  logic                pkt_dca,
    input  logic [CPU_W-1:0]    pkt_cpu,
    output logic                pkt_ready,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_rsp_valid,
    input  logic [2*ADDR_W-1:0] rd_rsp_data,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [1:0]          wr_kind,
    output logic [LEN_W-1:0]    wr_len,
    output logic                wr_dca,
    output logic [CPU_W-1:0]    wr_cpu,
    output logic                cons_inc,
    output logic [DROP_W-1:0]   drop_cnt
);
    localparam int LSH     = $clog2(LINE_BYTES);
    localparam int DSH     = $clog2(DESC_BYTES);
    localparam int LINES_W = LEN_W + 1 - LSH;

    typedef struct packed {
        seq_st_e            st;
        logic [LEN_W-1:0]   len;
        logic               dca;
        logic [CPU_W-1:0]   cpu;
        logic [ADDR_W-1:0]  hdr;
        logic [ADDR_W-1:0]  pay;
        logic [LINES_W-1:0] left;
        logic [DROP_W-1:0]  drops;
    } seq_t;

    seq_t s_d, s_q;
    logic [LEN_W:0]     len_rnd;
    logic [ADDR_W-1:0]  desc_addr;

    assign len_rnd   = {1'b0, pkt_len} + (LEN_W+1)'(LINE_BYTES - 1);
    assign desc_addr = ring_base + (ADDR_W'(cons_idx) << DSH);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: if (pkt_valid) begin
                if (ring_empty) begin
                    s_d.drops = s_q.drops + DROP_W'(1);
                end else begin
                    s_d.len  = pkt_len;
                    s_d.dca  = pkt_dca;
                    s_d.cpu  = pkt_cpu;
                    s_d.left = len_rnd[LEN_W:LSH];
                    s_d.st   = ST_DRD;
                end
            end
            ST_DRD:   if (rd_ready) s_d.st = ST_DWAIT;
            ST_DWAIT: if (rd_rsp_valid) begin
                s_d.hdr = rd_rsp_data[ADDR_W-1:0];
                s_d.pay = rd_rsp_data[2*ADDR_W-1:ADDR_W];
                s_d.st  = ST_HDR;
            end
            ST_HDR:   if (wr_ready) s_d.st = (s_q.left != '0) ? ST_PAY : ST_STS;
            ST_PAY:   if (wr_ready) begin
                s_d.pay  = s_q.pay + ADDR_W'(LINE_BYTES);
                s_d.left = s_q.left - LINES_W'(1);
                if (s_q.left == LINES_W'(1)) s_d.st = ST_STS;
            end
            ST_STS:   if (wr_ready) s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        wr_addr = desc_addr;
        wr_kind = WK_STS;
        unique case (s_q.st)
            ST_HDR:  begin wr_addr = s_q.hdr; wr_kind = WK_HDR; end
            ST_PAY:  begin wr_addr = s_q.pay; wr_kind = WK_PAY; end
            default: begin wr_addr = desc_addr; wr_kind = WK_STS; end
        endcase
    end

    assign pkt_ready = (s_q.st == ST_IDLE);
    assign rd_valid  = (s_q.st == ST_DRD);
    assign rd_addr   = desc_addr;
    assign wr_valid  = (s_q.st == ST_HDR) || (s_q.st == ST_PAY) || (s_q.st == ST_STS);
    assign wr_len    = (s_q.st == ST_STS) ? s_q.len : '0;
    assign wr_dca    = s_q.dca;
    assign wr_cpu    = s_q.cpu;
    assign cons_inc  = (s_q.st == ST_STS) && wr_ready;
    assign drop_cnt  = s_q.drops;
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
    parameter int IDX_W   = 4,
    parameter int ADDR_W  = 32,
    parameter int CPU_W   = 3,
    parameter int LEN_W   = 11,
    parameter int DROP_W  = 8,
    parameter int PKT_THR = 4,
    parameter int TMR_THR = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic                tail_wr,
    input  logic [IDX_W-1:0]    tail_val,
    input  logic                pkt_valid,
    input  logic [LEN_W-1:0]    pkt_len,
    input  logic                pkt_dca,
    input  logic [CPU_W-1:0]    pkt_cpu,
    output logic                pkt_ready,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_rsp_valid,
    input  logic [2*ADDR_W-1:0] rd_rsp_data,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [1:0]          wr_kind,
    output logic [LEN_W-1:0]    wr_len,
    output logic                wr_dca,
    output logic [CPU_W-1:0]    wr_cpu,
    output logic                irq,
    input  logic                irq_ack,
    output logic [IDX_W-1:0]    cons_idx,
    output logic [DROP_W-1:0]   drop_cnt
);
    logic [IDX_W-1:0] prod_idx;
    logic             ring_empty;
    logic             cons_inc;

    rxr_ring_ptr #(.IDX_W(IDX_W)) i_ptr (
        .clk(clk), .rst_n(rst_n),
        .tail_wr(tail_wr), .tail_val(tail_val), .cons_inc(cons_inc),
        .prod_idx(prod_idx), .cons_idx(cons_idx), .ring_empty(ring_empty)
    );

    rxr_seq #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CPU_W(CPU_W),
        .LEN_W(LEN_W), .DROP_W(DROP_W)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .ring_base(ring_base), .cons_idx(cons_idx), .ring_empty(ring_empty),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_dca(pkt_dca),
        .pkt_cpu(pkt_cpu), .pkt_ready(pkt_ready),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_kind(wr_kind), .wr_len(wr_len), .wr_dca(wr_dca), .wr_cpu(wr_cpu),
        .cons_inc(cons_inc), .drop_cnt(drop_cnt)
    );

    rxr_irq_mod #(.PKT_THR(PKT_THR), .TMR_THR(TMR_THR)) i_irq (
        .clk(clk), .rst_n(rst_n),
        .pkt_done(cons_inc), .irq_ack(irq_ack), .irq(irq)
    );
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 32,
    parameter int CPU_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_valid,
    input logic              pkt_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_kind,
    input logic              wr_dca,
    input logic [CPU_W-1:0]  wr_cpu,
    input logic              irq,
    input logic              irq_ack,
    input logic [IDX_W-1:0]  cons_idx,
    input logic [IDX_W-1:0]  prod_idx
);
    // R7: a stalled write keeps its address and tags
    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_kind)
                                  && $stable(wr_dca) && $stable(wr_cpu));

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    // R3: a packet taken on an empty ring issues no read
    assert_drop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_ready && (cons_idx == prod_idx) |=> !rd_valid);

    // R4: descriptor fetch and line writes never overlap
    assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    // R8: consumer index only steps by one, and does so after a status write
    assert_cons_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cons_idx) |-> cons_idx == IDX_W'($past(cons_idx) + IDX_W'(1)));

    assert_sts_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && wr_kind == 2'd2 |=> cons_idx == IDX_W'($past(cons_idx) + IDX_W'(1)));

    // R11: interrupt holds until acknowledged, then drops
    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq);

    assert_irq_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq);
endmodule

bind rx_ring_engine rxr_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) i_rxr_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_kind(wr_kind), .wr_dca(wr_dca), .wr_cpu(wr_cpu),
    .irq(irq), .irq_ack(irq_ack), .cons_idx(cons_idx), .prod_idx(prod_idx)
);

// File: tb/test_rx_ring_engine.sv
`timescale 1ns/1ps
module test_rx_ring_engine;
    localparam int TMR_THR = 64;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tail_wr = 1'b0;
    logic [3:0]  tail_val = '0;
    logic        pkt_valid = 1'b0;
    logic [10:0] pkt_len = '0;
    logic        pkt_dca = 1'b0;
    logic [2:0]  pkt_cpu = '0;
    logic        pkt_ready;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [31:0] rd_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [31:0] wr_addr;
    logic [1:0]  wr_kind;
    logic [10:0] wr_len;
    logic        wr_dca;
    logic [2:0]  wr_cpu;
    logic        irq;
    logic        irq_ack = 1'b0;
    logic [3:0]  cons_idx;
    logic [7:0]  drop_cnt;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0, stall = 0, rsp_pend = 0;
    logic [31:0] wa [0:31];
    logic [1:0]  wk [0:31];
    logic        wd [0:31];
    logic [2:0]  wc [0:31];
    logic [10:0] wl [0:31];
    logic [31:0] ra [0:3];
    int wr_n = 0, rd_n = 0, sts_cyc = 0;

    rx_ring_engine i_rx_ring_engine (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE), .tail_wr(tail_wr), .tail_val(tail_val),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_dca(pkt_dca), .pkt_cpu(pkt_cpu),
        .pkt_ready(pkt_ready), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_kind(wr_kind),
        .wr_len(wr_len), .wr_dca(wr_dca), .wr_cpu(wr_cpu),
        .irq(irq), .irq_ack(irq_ack), .cons_idx(cons_idx), .drop_cnt(drop_cnt)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model: descriptor data one cycle after the accepted request
    always @(negedge clk) begin
        rd_rsp_valid <= rsp_pend;
        rsp_pend     <= rd_valid && rd_ready;
        if (rd_valid && rd_ready)
            rd_rsp_data <= {32'h8000_0000 + (rd_addr << 8), 32'h4000_0000 + (rd_addr << 8)};
        wr_ready <= stall ? ~wr_ready : 1'b1;
    end

    // monitor of accepted requests
    always @(negedge clk) begin
        if (wr_valid && wr_ready && wr_n < 32) begin
            wa[wr_n] = wr_addr; wk[wr_n] = wr_kind; wd[wr_n] = wr_dca;
            wc[wr_n] = wr_cpu;  wl[wr_n] = wr_len;
            if (wr_kind == 2'd2) sts_cyc = cyc;
            wr_n++;
        end
        if (rd_valid && rd_ready && rd_n < 4) begin
            ra[rd_n] = rd_addr; rd_n++;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic send_pkt(int len, bit dca, logic [2:0] cpu);
        rd_n = 0; wr_n = 0;
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = 11'(len); pkt_dca = dca; pkt_cpu = cpu;
        while (!pkt_ready) @(negedge clk);
        @(negedge clk);
        pkt_valid = 1'b0; pkt_dca = ~dca; pkt_cpu = ~cpu;   // R6 later changes ignored
        while (!pkt_ready) @(negedge clk);
    endtask

    task automatic set_tail(int v);
        @(negedge clk); tail_wr = 1'b1; tail_val = 4'(v);
        @(negedge clk); tail_wr = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic check_pkt(int c, int len, bit dca, logic [2:0] cpu, string cnt_req);
        logic [31:0] desc = BASE + 32'(c) * 16;
        int n = (len + 63) / 64;
        chk("R2 read count", 32'(rd_n), 1);
        chk("R2 descriptor address", ra[0], desc);
        chk({cnt_req, " write count"}, 32'(wr_n), 32'(n + 2));
        if (wr_n == n + 2) begin
            chk("R4 header kind", 32'(wk[0]), 0);
            chk("R4 header address", wa[0], 32'h4000_0000 + (desc << 8));
            for (int i = 1; i <= n; i++) begin
                chk("R4 payload kind", 32'(wk[i]), 1);
                chk("R4 payload address", wa[i], 32'h8000_0000 + (desc << 8) + 32'(64 * (i - 1)));
            end
            chk("R4 status kind", 32'(wk[n+1]), 2);
            chk("R4 status address", wa[n+1], desc);
            chk("R4 status length", 32'(wl[n+1]), 32'(len));
            for (int i = 0; i <= n + 1; i++) begin
                chk("R6 dca tag", 32'(wd[i]), 32'(dca));
                chk("R6 cpu tag", 32'(wc[i]), 32'(cpu));
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 wr_valid", 32'(wr_valid), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 cons_idx", 32'(cons_idx), 0);
        chk("R1 drop_cnt", 32'(drop_cnt), 0);
        chk("R1 pkt_ready", 32'(pkt_ready), 1);
    endtask

    task automatic t_drop_empty();
        send_pkt(100, 1'b1, 3'd1);
        chk("R3 drop count", 32'(drop_cnt), 1);
        chk("R3 no reads", 32'(rd_n), 0);
        chk("R3 no writes", 32'(wr_n), 0);
        chk("R3 cons unchanged", 32'(cons_idx), 0);
    endtask

    task automatic t_basic();
        set_tail(15);                       // R12 producer update
        send_pkt(200, 1'b1, 3'd5);
        check_pkt(0, 200, 1'b1, 3'd5, "R12");
        chk("R8 cons after one packet", 32'(cons_idx), 1);
        chk("R12 no drop after tail write", 32'(drop_cnt), 1);
    endtask

    task automatic t_zero_len();
        send_pkt(0, 1'b0, 3'd2);
        check_pkt(1, 0, 1'b0, 3'd2, "R5");
    endtask

    task automatic t_max_stall();
        stall = 1;
        send_pkt(1460, 1'b1, 3'd7);
        stall = 0;
        check_pkt(2, 1460, 1'b1, 3'd7, "R7 R4");
    endtask

    task automatic t_timer();
        int first = -1;
        ack();
        chk("R11 irq low after ack", 32'(irq), 0);
        send_pkt(64, 1'b0, 3'd0);
        for (int i = 0; i < 200 && first < 0; i++) begin
            if (irq) first = cyc;
            else @(negedge clk);
        end
        chk("R10 timer latency", 32'(first), 32'(sts_cyc + 1 + TMR_THR));
    endtask

    task automatic t_count();
        ack();
        for (int i = 0; i < 3; i++) send_pkt(0, 1'b0, 3'd3);
        chk("R9 irq low below threshold", 32'(irq), 0);
        send_pkt(0, 1'b0, 3'd3);
        chk("R9 irq at packet threshold", 32'(irq), 1);
    endtask

    task automatic t_hold_ack();
        repeat (20) @(negedge clk);
        chk("R11 irq held without ack", 32'(irq), 1);
        ack();
        chk("R11 irq cleared by ack", 32'(irq), 0);
        send_pkt(0, 1'b0, 3'd4);
        chk("R11 counts cleared by ack", 32'(irq), 0);
    endtask

    task automatic t_wrap();
        set_tail(3);
        for (int i = 0; i < 7; i++) send_pkt(64, 1'b1, 3'd6);
        chk("R8 cons wraps to zero", 32'(cons_idx), 0);
        send_pkt(64, 1'b0, 3'd1);
        check_pkt(0, 64, 1'b0, 3'd1, "R8");
        send_pkt(64, 1'b0, 3'd1);
        send_pkt(64, 1'b0, 3'd1);
        chk("R12 cons reaches producer", 32'(cons_idx), 3);
        send_pkt(64, 1'b0, 3'd1);
        chk("R3 drop after wrap", 32'(drop_cnt), 2);
        chk("R3 no writes after wrap drop", 32'(wr_n), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drop_empty();
        t_basic();
        t_zero_len();
        t_max_stall();
        t_timer();
        t_count();
        t_hold_ack();
        t_wrap();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule